// File: doc/BRIEF.md
# Lockable GPIO Bank Register File

This block is the register side of a general-purpose pin controller. It serves up to eight banks of 32 pins through a plain 32-bit register bus with a write strobe, a byte address and a combinational read port. Every pin has its own control word, and bit 0 of that word picks the pin's direction. Every bank has a register to set output bits, a register to clear output bits, and two read-only views: the driven output levels and the sampled input levels. The pins arrive through a two-flop synchroniser. The block drives an output level and an output enable for every pin.

Each bank also has a lock word with one bit per pin; a 1 write-protects that pin. The lock word cannot be changed by an ordinary write. Software must first store the password 0x00A5A501 at offset 0x520, and the very next bus write must be the lock write. Any other write in between disarms the password. A lock write that arrives without the password is discarded and raises a sticky error flag. Interrupt detection and debounce filtering live in other blocks.

Top module: `gpio_lockbank_top`

## Requirements
- R1: After reset every pin is an input (control bit 0 reads 1, `pin_oe` low), every output level is 0, every bank's lock word reads 0xFFFFFFFF and `lock_err` is 0.
- R2: Bank registers sit at a 4-byte stride from their bases: output level 0x000, input level 0x020, set 0x040, clear 0x060, lock 0x500. A pin's control word sits at 0x100 + 4*pin, and the global pin number splits into bank = pin>>5 and bit = pin&31.
- R3: Control bit 0 = 1 makes a pin an input and = 0 makes it an output. `pin_oe` is high exactly for the output pins.
- R4: Writing 1 to a bit of the set register raises that output level, and writing 1 to a bit of the clear register lowers it. Zero bits leave their levels unchanged.
- R5: For a pin whose lock bit is 1, writes to its control word and to its set and clear bits have no effect.
- R6: A lock write is accepted only when the previous bus write stored 0x00A5A501 at 0x520. The written word becomes the lock word: all ones locks the whole bank and all zeros unlocks it.
- R7: Any bus write other than the lock write disarms the password, including a write of a wrong value to 0x520. Idle cycles do not disarm it.
- R8: A lock write that arrives while the password is not armed leaves the lock word unchanged and sets `lock_err`, which stays high until reset.
- R9: The input-level register shows `pin_in` after the two synchroniser flops. A change becomes visible after the second rising edge and not after the first.
- R10: Reads of unmapped offsets return zero. This covers the password offset, registers of absent banks, control words of absent pins and addresses that are not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | NUM_BANKS*32 | Pin levels from the pads |
| pin_out | output | NUM_BANKS*32 | Output levels |
| pin_oe | output | NUM_BANKS*32 | Output enables, high for output pins |
| lock_err | output | 1 | Sticky flag for a rejected lock write |

## Verification
The hardest situation to reach is the password that has been armed and then disarmed: a correct password followed by an unrelated write, or a wrong password value, and then a lock write. The stimulus table places each of these sequences just before a read-back of the lock word, which must still hold its old value. A separate case puts only idle cycles between the password and the lock write, and that lock write must still be accepted. Locked pins are targeted with set, clear and direction writes, and the effect is read back both through the status registers and at `pin_out` and `pin_oe`.

// File: rtl/gpio_lockbank_pkg.sv
package gpio_lockbank_pkg;

  localparam int unsigned PINS_PER_BANK = 32;
  localparam int unsigned MAX_BANKS     = 8;
  localparam logic [31:0] PASSWORD      = 32'h00A5_A501;

  localparam int unsigned OFS_OUT_LVL = 12'h000;
  localparam int unsigned OFS_IN_LVL  = 12'h020;
  localparam int unsigned OFS_SET     = 12'h040;
  localparam int unsigned OFS_CLR     = 12'h060;
  localparam int unsigned OFS_CTRL    = 12'h100;
  localparam int unsigned OFS_LOCK    = 12'h500;
  localparam int unsigned OFS_PWD     = 12'h520;

  typedef enum logic [2:0] {
    K_NONE, K_OUT_LVL, K_IN_LVL, K_SET, K_CLR, K_CTRL, K_LOCK, K_PWD
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [2:0]  bank;
    logic [7:0]  pin;
  } dec_t;

  // bank number of a global pin
  function automatic logic [2:0] bank_of(input logic [7:0] pin);
    return pin[7:5];
  endfunction

  // bit index of a global pin inside its bank
  function automatic logic [4:0] bit_of(input logic [7:0] pin);
    return pin[4:0];
  endfunction

  function automatic logic [31:0] apply_set(input logic [31:0] lvl,
                                            input logic [31:0] mask,
                                            input logic [31:0] lock);
    return lvl | (mask & ~lock);
  endfunction

  function automatic logic [31:0] apply_clr(input logic [31:0] lvl,
                                            input logic [31:0] mask,
                                            input logic [31:0] lock);
    return lvl & ~(mask & ~lock);
  endfunction

  function automatic dec_t decode_addr(input logic [11:0] addr,
                                       input int unsigned nbanks);
    dec_t d;
    int unsigned ofs;
    int unsigned gpin;
    ofs    = 32'(addr);
    d.kind = K_NONE;
    d.bank = addr[4:2];
    d.pin  = 8'd0;
    if (addr[1:0] == 2'b00) begin
      if (ofs < OFS_CTRL) begin
        case (addr[7:5])
          3'd0: d.kind = K_OUT_LVL;
          3'd1: d.kind = K_IN_LVL;
          3'd2: d.kind = K_SET;
          3'd3: d.kind = K_CLR;
          default: d.kind = K_NONE;
        endcase
        if (32'(d.bank) >= nbanks) d.kind = K_NONE;
      end else if (ofs < OFS_LOCK) begin
        gpin  = (ofs - OFS_CTRL) >> 2;
        d.pin = gpin[7:0];
        d.bank = bank_of(d.pin);
        if (gpin < nbanks * PINS_PER_BANK) d.kind = K_CTRL;
      end else if (ofs < OFS_PWD) begin
        if (32'(d.bank) < nbanks) d.kind = K_LOCK;
      end else if (ofs == OFS_PWD) begin
        d.kind = K_PWD;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_pwd_guard.sv
module gpio_pwd_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_we,
  input  logic pwd_hit,
  input  logic lock_wr,
  output logic lock_ok,
  output logic lock_err
);
  logic armed_q;
  logic err_q;
  logic drop_ev;

  assign lock_ok = lock_wr & armed_q;
  assign drop_ev = lock_wr & ~armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (bus_we) armed_q <= pwd_hit;
      if (drop_ev) err_q <= 1'b1;
    end
  end

  assign lock_err = err_q;

  // R7
  disarm_on_other_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !pwd_hit) |=> !armed_q);

  // R8
  drop_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && !armed_q) |=> lock_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_lockbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_set,
  input  logic        we_clr,
  input  logic        we_ctrl,
  input  logic [4:0]  ctrl_idx,
  input  logic        ctrl_val,
  input  logic        we_lock,
  input  logic [31:0] wdata,
  output logic [31:0] lvl_q,
  output logic [31:0] dir_q,
  output logic [31:0] lock_q
);
  logic ctrl_blocked;
  assign ctrl_blocked = lock_q[ctrl_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      dir_q  <= '1;
      lock_q <= '1;
    end else begin
      if (we_lock) lock_q <= wdata;
      if (we_set) lvl_q <= apply_set(lvl_q, wdata, lock_q);
      else if (we_clr) lvl_q <= apply_clr(lvl_q, wdata, lock_q);
      if (we_ctrl && !ctrl_blocked) dir_q[ctrl_idx] <= ctrl_val;
    end
  end

  // R5
  locked_lvl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lvl_q ^ $past(lvl_q)) & $past(lock_q)) == 32'd0);

  // R5
  locked_dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dir_q ^ $past(dir_q)) & $past(lock_q)) == 32'd0);

  // R4
  set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> (lvl_q & $past(wdata & ~lock_q)) == $past(wdata & ~lock_q));

  // R6
  lock_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_lock |=> $stable(lock_q));
endmodule

// File: rtl/gpio_lockbank_top.sv
module gpio_lockbank_top
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NPINS = NUM_BANKS * PINS_PER_BANK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             lock_err
);
  dec_t dec;
  logic pwd_hit;
  logic lock_wr;
  logic lock_ok;
  logic [NPINS-1:0] in_sync;
  logic [31:0] lvl_b  [NUM_BANKS];
  logic [31:0] dir_b  [NUM_BANKS];
  logic [31:0] lock_b [NUM_BANKS];

  assign dec     = decode_addr(bus_addr, NUM_BANKS);
  assign pwd_hit = bus_we && (dec.kind == K_PWD) && (bus_wdata == PASSWORD);
  assign lock_wr = bus_we && (dec.kind == K_LOCK);

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_sync(in_sync)
  );

  gpio_pwd_guard u_guard (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .pwd_hit(pwd_hit),
    .lock_wr(lock_wr), .lock_ok(lock_ok), .lock_err(lock_err)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (dec.bank == 3'(b));
    gpio_bank_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .we_set(bus_we && dec.kind == K_SET && sel),
      .we_clr(bus_we && dec.kind == K_CLR && sel),
      .we_ctrl(bus_we && dec.kind == K_CTRL && sel),
      .ctrl_idx(bit_of(dec.pin)),
      .ctrl_val(bus_wdata[0]),
      .we_lock(lock_ok && sel),
      .wdata(bus_wdata),
      .lvl_q(lvl_b[b]), .dir_q(dir_b[b]), .lock_q(lock_b[b])
    );
    assign pin_out[b*PINS_PER_BANK +: PINS_PER_BANK] = lvl_b[b];
    assign pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]  = ~dir_b[b];
  end

  always_comb begin
    bus_rdata = 32'd0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec.bank == 3'(b)) begin
        case (dec.kind)
          K_OUT_LVL: bus_rdata = lvl_b[b];
          K_IN_LVL:  bus_rdata = in_sync[b*PINS_PER_BANK +: PINS_PER_BANK];
          K_LOCK:    bus_rdata = lock_b[b];
          K_CTRL:    bus_rdata = {31'd0, dir_b[b][bit_of(dec.pin)]};
          default:   bus_rdata = 32'd0;
        endcase
      end
    end
  end

  // R10
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == K_NONE || dec.kind == K_PWD) |-> bus_rdata == 32'd0);

  // R3
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && dec.kind == K_CTRL && !lock_b[0][bit_of(dec.pin)] && dec.bank == 3'd0)
      |=> pin_oe[bit_of($past(dec.pin))] == !$past(bus_wdata[0]));
endmodule

// File: tb/gpio_lockbank_top_bench.sv
module gpio_lockbank_top_bench;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic lock_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_lockbank_top #(.NUM_BANKS(NB)) u_gpio_lockbank_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .lock_err(lock_err)
  );

  typedef struct packed {
    logic        rd;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h040, 32'h0000_00FF, 4'd5},  // R5 set while bank locked
    '{1'b1, 12'h000, 32'h0000_0000, 4'd5},
    '{1'b0, 12'h500, 32'h0000_0000, 4'd8},  // R8 lock write, no password
    '{1'b1, 12'h500, 32'hFFFF_FFFF, 4'd8},
    '{1'b0, 12'h520, 32'h00A5_A501, 4'd6},  // R6 password then unlock low half
    '{1'b0, 12'h500, 32'hFFFF_0000, 4'd6},
    '{1'b1, 12'h500, 32'hFFFF_0000, 4'd6},
    '{1'b0, 12'h10C, 32'h0000_0000, 4'd3},  // R3 pin 3 to output
    '{1'b1, 12'h10C, 32'h0000_0000, 4'd3},
    '{1'b0, 12'h150, 32'h0000_0000, 4'd5},  // R5 pin 20 locked
    '{1'b1, 12'h150, 32'h0000_0001, 4'd5},
    '{1'b0, 12'h040, 32'hFFFF_FFFF, 4'd4},  // R4 set all, locked bits stay
    '{1'b1, 12'h000, 32'h0000_FFFF, 4'd4},
    '{1'b0, 12'h060, 32'h0000_000F, 4'd4},  // R4 clear low nibble
    '{1'b1, 12'h000, 32'h0000_FFF0, 4'd4},
    '{1'b0, 12'h060, 32'h0000_0000, 4'd4},  // R4 zero bits no effect
    '{1'b1, 12'h000, 32'h0000_FFF0, 4'd4},
    '{1'b0, 12'h520, 32'h00A5_A501, 4'd7},  // R7 other write disarms
    '{1'b0, 12'h040, 32'h0000_0000, 4'd7},
    '{1'b0, 12'h500, 32'h0000_0000, 4'd7},
    '{1'b1, 12'h500, 32'hFFFF_0000, 4'd7},
    '{1'b0, 12'h520, 32'h00A5_A500, 4'd7},  // R7 wrong password value
    '{1'b0, 12'h500, 32'h0000_0000, 4'd7},
    '{1'b1, 12'h500, 32'hFFFF_0000, 4'd7},
    '{1'b0, 12'h520, 32'h00A5_A501, 4'd2},  // R2 unlock bank 1 at stride 4
    '{1'b0, 12'h504, 32'h0000_0000, 4'd2},
    '{1'b1, 12'h504, 32'h0000_0000, 4'd2},
    '{1'b0, 12'h194, 32'h0000_0000, 4'd2},  // R2 pin 37 = bank 1 bit 5
    '{1'b1, 12'h194, 32'h0000_0000, 4'd2},
    '{1'b1, 12'h000, 32'h0000_FFF0, 4'd2}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1;
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_chk("R1", 12'h500, 32'hFFFF_FFFF);
    read_chk("R1", 12'h504, 32'hFFFF_FFFF);
    read_chk("R1", 12'h180, 32'h0000_0001);
    check("R1", pin_oe, 64'd0);
    check("R1", pin_out, 64'd0);
    check("R1", 64'(lock_err), 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) read_chk($sformatf("R%0d", VEC[i].r), VEC[i].a, VEC[i].d);
      else bus_write(VEC[i].a, VEC[i].d);
    end

    // R8 sticky error after the dropped lock writes
    check("R8", 64'(lock_err), 64'd1);
    // R3 only pins 3 and 37 drive
    @(negedge clk);
    check("R3", pin_oe, (64'd1 << 3) | (64'd1 << 37));
    check("R4", pin_out, 64'h0000_0000_0000_FFF0);

    // R7 idle cycles keep the password armed
    bus_write(12'h520, 32'h00A5_A501);
    repeat (4) @(negedge clk);
    bus_write(12'h500, 32'h0000_00FF);
    read_chk("R7", 12'h500, 32'h0000_00FF);
    // R5 now pins 0..7 locked: clear of them is ignored
    bus_write(12'h060, 32'h0000_FFFF);
    read_chk("R5", 12'h000, 32'h0000_00F0);

    // R9 two-flop input path on bank 1
    @(negedge clk);
    pin_in = 64'h0000_00A5_0000_0000;
    bus_addr = 12'h024;
    @(negedge clk); #1;
    check("R9", 64'(bus_rdata), 64'd0);
    @(negedge clk); #1;
    check("R9", 64'(bus_rdata), 64'h0000_00A5);

    // R10 unmapped offsets
    read_chk("R10", 12'h520, 32'd0);
    read_chk("R10", 12'h008, 32'd0);
    read_chk("R10", 12'h600, 32'd0);
    read_chk("R10", 12'h501, 32'd0);
    read_chk("R10", 12'h200, 32'd0);
    read_chk("R10", 12'h080, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule